// File: doc/BRIEF.md
# Key-Authenticated Obfuscating Scan Chain

This block is one scan chain with a test-authorization check built into it. The chain has three consecutive segments. The first segment holds the cells that are compared against a secret test key. The second segment holds the flag cell that marks the end of key loading. The third segment holds gates that corrupt the shifted data. The key lives in ordinary scan cells, and it is checked while the tester's stream passes through them, so no separate key register is needed.

A test session opens with a rising edge on scan-in, which is the start bit. The tester then shifts the key so that it sits on the tap cells before the start bit reaches the flag cell. If the key matches in time, the enable flag is set and stays set until reset. The chain then behaves as a plain shift register, delivering each bit to scan-out exactly as it went in.

If the flag cell sees the start bit while the enable flag is still clear, the input lock drops for good and three things follow:
- scan-in is ignored;
- the first segment recirculates on itself every shift clock;
- the third segment keeps zero-gating data wherever a tap cell disagrees with its key bit.

All geometry is fixed at elaboration: key length, key-tap positions, key polarities, flag position and obfuscation points.

Top module: `scan_auth_chain`

## Requirements
- R1: After reset, `key_ok` is 0, `load_done_n` is 1, `in_open` is 0 and every chain cell (`func_q`) is 0.
- R2: With `scan_en` low, every cell captures its `func_d` bit on the next clock edge.
- R3: With `scan_en` high, the first clock edge that sees `scan_in` at 1 (after a 0, or as the first sample after reset) is the start bit. That bit enters cell 0 on that edge, and `in_open` reads 1 after it.
- R4: `load_done_n` is the inverse of the flag cell, which is chain position 10 by default. It goes low on the edge that moves the start bit into that cell.
- R5: When every tap cell holds its key bit while `in_open` is 1, `key_ok` rises on the next edge and stays 1 until reset. By default the taps are positions 1, 3, 4 and 6, with expected bits 1, 0, 1 and 1.
- R6: While `key_ok` is 1 and `scan_en` is high, the chain shifts without alteration. A bit driven on `scan_in` reaches `scan_out` after CHAIN_LEN - 1 further edges.
- R7: If `load_done_n` is low while `key_ok` is 0, `in_open` falls on the next edge and stays 0 until reset. After that, `key_ok` can no longer rise.
- R8: While locked with `scan_en` high, `scan_in` is ignored. Cell 0 takes the value of the last cell of the first segment, so the first segment (positions 0 to 7 by default) rotates by one place per clock.
- R9: While `key_ok` is 0, each obfuscation point is driven by one tap. The point captures 0 on a shift whenever that tap cell differs from its key bit. By default, position 12 is driven by the tap at position 3 (key bit 0) and position 14 by the tap at position 1 (key bit 1).
- R10: A correct key that lands on the taps only after the start bit has reached the flag cell still leaves the chain locked, with `key_ok` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | 1: shift, 0: functional capture |
| scan_in | input | 1 | Serial scan data; its first rise is the start bit |
| func_d | input | CHAIN_LEN | Functional data-in, one bit per cell |
| func_q | output | CHAIN_LEN | Functional data-out, one bit per cell |
| scan_out | output | 1 | Serial scan data, last cell of the chain |
| key_ok | output | 1 | Authorization granted (sticky) |
| in_open | output | 1 | Scan-in connected to the chain |
| load_done_n | output | 1 | Inverted flag cell; low once key loading ends |

The serial interface is a plain bit-per-clock shift with no handshake: every edge with `scan_en` high moves the chain, and the tester can never be stalled.

## Verification
The bench builds the block with its default geometry:
- a 16-cell chain with an 8-cell first segment;
- a 4-bit key on taps 1, 3, 4 and 6;
- the flag at position 10;
- obfuscation at positions 12 and 14.

This short chain puts the exact edge of authentication in reach: a key matched one cycle before the flag is accepted, while the same key two cycles later is refused. It also makes a known first-segment pattern small enough to follow through a full rotation, and it lets a single capture-and-shift show a zero forced at an obfuscation point.

// File: rtl/scan_auth_pkg.sv
package scan_auth_pkg;
  // A tap disagrees with its key bit when the cell differs from the expected value.
  function automatic logic tap_mismatch(input logic cell_v, input logic key_bit);
    return cell_v ^ key_bit;
  endfunction
endpackage

// File: rtl/scan_auth_keycheck.sv
module scan_auth_keycheck
  import scan_auth_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned KEY_W     = 4,
  parameter logic [KEY_W-1:0] KEY_BITS = 4'b1101,
  parameter int unsigned OBF_CNT   = 2,
  parameter int unsigned OBF_POS [OBF_CNT] = '{12, 14},
  parameter int unsigned OBF_SEL [OBF_CNT] = '{1, 0}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KEY_W-1:0]     tap_bits,
  input  logic                 in_open,
  output logic [CHAIN_LEN-1:0] pass_mask,
  output logic                 key_ok
);
  logic [KEY_W-1:0] nand_n;
  logic match_all, match_q, ok_q;

  for (genvar k = 0; k < KEY_W; k++) begin : g_tap
    assign nand_n[k] = ~(tap_mismatch(tap_bits[k], KEY_BITS[k]) & ~ok_q);
  end

  assign match_all = (&nand_n) & in_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      match_q <= match_all;
      if (match_all && !match_q) ok_q <= 1'b1;
    end
  end

  always_comb begin
    pass_mask = '1;
    for (int o = 0; o < int'(OBF_CNT); o++)
      pass_mask[OBF_POS[o]] = pass_mask[OBF_POS[o]] & nand_n[OBF_SEL[o]];
  end

  assign key_ok = ok_q;

  // R5
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ok_q |=> ok_q);
  // R7
  no_grant_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_open && !ok_q) |=> !ok_q);
endmodule

// File: rtl/scan_auth_lockctl.sv
module scan_auth_lockctl (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic scan_in,
  input  logic load_done_n,
  input  logic key_ok,
  input  logic recirc_bit,
  output logic chain_in,
  output logic locked,
  output logic in_open
);
  logic si_q, start_q, fail_q, lock_q;
  logic si_rise, fail_now, admit;

  assign si_rise  = scan_en & scan_in & ~si_q;
  assign fail_now = ~(key_ok | load_done_n);
  assign admit    = (start_q | si_rise) & ~lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q    <= 1'b0;
      start_q <= 1'b0;
      fail_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      si_q   <= scan_in;
      fail_q <= fail_now;
      if (si_rise) start_q <= 1'b1;
      if (fail_now && !fail_q) lock_q <= 1'b1;
    end
  end

  assign chain_in = lock_q ? recirc_bit : (admit & scan_in);
  assign locked   = lock_q;
  assign in_open  = start_q & ~lock_q;

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> lock_q);
  // R7
  lock_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> !$past(key_ok));
  // R3
  start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) start_q |=> start_q);
endmodule

// File: rtl/scan_auth_cells.sv
module scan_auth_cells #(
  parameter int unsigned CHAIN_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en,
  input  logic                 chain_in,
  input  logic [CHAIN_LEN-1:0] pass_mask,
  input  logic [CHAIN_LEN-1:0] func_d,
  output logic [CHAIN_LEN-1:0] cells
);
  logic [CHAIN_LEN-1:0] shift_src, nxt;

  assign shift_src = {cells[CHAIN_LEN-2:0], chain_in};

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    assign nxt[i] = scan_en ? (shift_src[i] & pass_mask[i]) : func_d[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cells[i] <= 1'b0;
      else        cells[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/scan_auth_chain.sv
module scan_auth_chain #(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned SEG1_LEN  = 8,
  parameter int unsigned KEY_W     = 4,
  parameter int unsigned KEY_TAP [KEY_W] = '{1, 3, 4, 6},
  parameter logic [KEY_W-1:0] KEY_BITS = 4'b1101,
  parameter int unsigned FLAG_POS  = 10,
  parameter int unsigned OBF_CNT   = 2,
  parameter int unsigned OBF_POS [OBF_CNT] = '{12, 14},
  parameter int unsigned OBF_SEL [OBF_CNT] = '{1, 0}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] func_d,
  output logic [CHAIN_LEN-1:0] func_q,
  output logic                 scan_out,
  output logic                 key_ok,
  output logic                 in_open,
  output logic                 load_done_n
);
  localparam int unsigned RECIRC_POS = SEG1_LEN - 1;
  localparam int unsigned LAST_POS   = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] cells, pass_mask;
  logic [KEY_W-1:0]     tap_bits;
  logic                 chain_in, locked;

  for (genvar k = 0; k < KEY_W; k++) begin : g_tapsel
    assign tap_bits[k] = cells[KEY_TAP[k]];
  end

  assign load_done_n = ~cells[FLAG_POS];

  scan_auth_keycheck #(
    .CHAIN_LEN(CHAIN_LEN), .KEY_W(KEY_W), .KEY_BITS(KEY_BITS),
    .OBF_CNT(OBF_CNT), .OBF_POS(OBF_POS), .OBF_SEL(OBF_SEL)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .tap_bits(tap_bits), .in_open(in_open),
    .pass_mask(pass_mask), .key_ok(key_ok)
  );

  scan_auth_lockctl u_lock (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .load_done_n(load_done_n), .key_ok(key_ok), .recirc_bit(cells[RECIRC_POS]),
    .chain_in(chain_in), .locked(locked), .in_open(in_open)
  );

  scan_auth_cells #(.CHAIN_LEN(CHAIN_LEN)) u_cells (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chain_in(chain_in),
    .pass_mask(pass_mask), .func_d(func_d), .cells(cells)
  );

  assign func_q   = cells;
  assign scan_out = cells[LAST_POS];

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> cells == $past(func_d));
  // R6
  transparent_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && scan_en) |=> cells[LAST_POS:1] == $past(cells[LAST_POS-1:0]));
  // R8
  recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && scan_en) |=> cells[0] == $past(cells[RECIRC_POS]));
endmodule

// File: tb/scan_auth_chain_tb_top.sv
module scan_auth_chain_tb_top;
  localparam int L = 16;

  typedef struct packed {
    logic [L-1:0] din;
    logic [L-1:0] exp;
    logic         chk;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{din: 16'hA5C3, exp: 16'h0000, chk: 1'b0},
    '{din: 16'h1234, exp: 16'hA5C3, chk: 1'b1},
    '{din: 16'hFFFF, exp: 16'h1234, chk: 1'b1},
    '{din: 16'h0001, exp: 16'hFFFF, chk: 1'b1},
    '{din: 16'h8000, exp: 16'h0001, chk: 1'b1},
    '{din: 16'h0000, exp: 16'h8000, chk: 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
  logic [L-1:0] func_d = '0;
  logic [L-1:0] func_q;
  logic scan_out, key_ok, in_open, load_done_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  scan_auth_chain dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_d(func_d), .func_q(func_q), .scan_out(scan_out),
    .key_ok(key_ok), .in_open(in_open), .load_done_n(load_done_n)
  );

  task automatic chk(input string req, input logic [L-1:0] got, input logic [L-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scan_en = 1'b0; scan_in = 1'b0; func_d = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic shift(input logic b);
    scan_en = 1'b1; scan_in = b;
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [L-1:0] s, input int n);
    for (int i = 0; i < n; i++) shift(s[i]);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [L-1:0] got;

    // Correct key: start bit, then key bits placed one cycle before the flag
    do_reset();
    chk("R1 key_ok", {15'd0, key_ok}, 16'd0);
    chk("R1 load_done_n", {15'd0, load_done_n}, 16'd1);
    chk("R1 in_open", {15'd0, in_open}, 16'd0);
    chk("R1 cells", func_q, 16'h0000);
    shift(1'b1);
    chk("R3 in_open", {15'd0, in_open}, 16'd1);
    chk("R3 start bit", func_q, 16'h0001);
    push(16'h0129 >> 1, 9);
    chk("R5 not yet", {15'd0, key_ok}, 16'd0);
    chk("R4 flag high", {15'd0, load_done_n}, 16'd1);
    shift(1'b0);
    chk("R5 granted", {15'd0, key_ok}, 16'd1);
    chk("R4 flag low", {15'd0, load_done_n}, 16'd0);
    shift(1'b0); shift(1'b0);
    chk("R7 stays open", {15'd0, in_open}, 16'd1);

    // R6: table-driven shift-through after authorization
    for (int v = 0; v < 6; v++) begin
      got = '0;
      for (int b = 0; b < L; b++) begin
        got[b] = scan_out;
        shift(VEC[v].din[b]);
      end
      if (VEC[v].chk) chk("R6 shift-through", got, VEC[v].exp);
    end
    chk("R5 sticky", {15'd0, key_ok}, 16'd1);

    // Wrong key: lock-out and recirculation
    do_reset();
    push(16'h068B, 11);
    chk("R7 before lock", {14'd0, in_open, key_ok}, 16'd2);
    shift(1'b0);
    chk("R7 locked", {15'd0, in_open}, 16'd0);
    chk("R8 seg1 at lock", {8'd0, func_q[7:0]}, 16'h0016);
    shift(1'b1);
    chk("R8 rotate one", {8'd0, func_q[7:0]}, 16'h002C);
    push(16'hFFFF, 7);
    chk("R8 full turn", {8'd0, func_q[7:0]}, 16'h0016);
    chk("R7 permanent", {14'd0, in_open, key_ok}, 16'd0);

    // R10: correct key two cycles late
    do_reset();
    push(16'h04A1, 12);
    chk("R10 locked", {14'd0, in_open, key_ok}, 16'd0);
    push(16'h0000, 4);
    chk("R10 no grant", {15'd0, key_ok}, 16'd0);

    // R2 capture and R9 obfuscation zero-gating
    do_reset();
    scan_en = 1'b0; func_d = 16'hFBFF;
    @(posedge clk); #1;
    chk("R2 capture", func_q, 16'hFBFF);
    shift(1'b0);
    chk("R9 obfuscated shift", func_q, 16'hE7FE);

    // R1 again after a locked session
    do_reset();
    chk("R1 after relock", {13'd0, key_ok, in_open, load_done_n}, 16'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule